// File: doc/BRIEF.md
# Bus Wait-State Control Unit

This unit sits between a CPU-side request port and the chip's bus. It stretches each bus cycle according to one 8-bit control register. Every request carries an address, a write strobe and write data. The unit decides whether the address falls in the peripheral register area or in external memory. It then holds the cycle for a programmed number of extra clocks. For external memory in handshake mode, it instead holds the cycle until an external ready input is sampled high. A one-clock done pulse goes back to the requester when the cycle completes.

A bus cycle with no wait states lasts two clocks, and each wait state adds one clock. In handshake mode a watchdog ends the cycle after 255 clocks without ready, and flags an error. The control register sits at a fixed address inside the peripheral area. Besides the wait settings, it holds two bits that leave the unit as plain outputs: one picks the base address of the interrupt vector table, the other allows software to write interrupt request flags.

The register layout is, from bit 7 down to bit 0:
- `per_wait[1:0]`
- `vec_sel`
- `irq_wen`
- `fixed_mode`
- `rsvd`
- `ext_wait[1:0]`

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset the control register reads 0xCB, `rsp_done` and `rsp_err` are low, `vec_base` is 0x04000 and `irq_flag_wr_en` is 0.
- R2: With `fixed_mode` (bit 3) = 1, an external access (address below 0xF000) lasts 2 + N clocks, where N = 0, 1, 2, 3 for `ext_wait` (bits 1:0) = 00, 01, 10, 11. `ext_ready` has no effect on such a cycle.
- R3: An access at or above 0xF000 lasts 2 + N clocks, where N is `per_wait` (bits 7:6, same encoding). This holds in either mode, and `ext_ready` is ignored.
- R4: With `fixed_mode` = 0, an external access ends on the first clock edge after acceptance at which `ext_ready` is sampled high. It therefore lasts 2 + (number of low samples) clocks, and `ext_wait` is ignored.
- R5: In handshake mode, 255 consecutive low samples of `ext_ready` end the cycle, 256 clocks after acceptance, with `rsp_err` high together with `rsp_done`.
- R6: Address 0xF001 reads and writes the control register and uses the `per_wait` timing. Bit 2 always reads 0. An external write leaves the register unchanged.
- R7: A register write takes effect when that write cycle completes. The write cycle itself keeps the wait count that was latched when it was accepted.
- R8: `vec_base` is 0x04000 when `vec_sel` (bit 5) is 0 and 0x00100 when it is 1.
- R9: `irq_flag_wr_en` equals `irq_wen` (bit 4). It is 0 to block software writes of interrupt request flags and 1 to allow them.
- R10: A read of any address other than 0xF001 returns `bus_rdata` on `rsp_rdata` while `rsp_done` is high.
- R11: `rsp_done` is a one-clock pulse. `rsp_err` is low for every cycle that ends normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when the unit is idle |
| req_addr | input | ADDR_W (16) | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| bus_rdata | input | 8 | Read data from the bus for non-register reads |
| ext_ready | input | 1 | External ready, used for handshake cycles |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Watchdog abort, high together with `rsp_done` |
| rsp_rdata | output | 8 | Read data, valid while `rsp_done` is high |
| vec_base | output | VEC_W (20) | Interrupt vector table base |
| irq_flag_wr_en | output | 1 | Software write enable for interrupt request flags |

## Verification
The bound checker watches four properties on every cycle:
- an error appears only with a done pulse;
- done never lasts two clocks;
- the register and both exported outputs change only on the clock where a cycle completes;
- no cycle stays busy past the watchdog bound.

Only the bench scenarios can show the exact length of each wait code, the handshake timing against `ext_ready`, and the delayed effect of a register write. The same holds for register readback with the reserved bit forced to 0, the read-data steering, and the abort after 255 low ready samples.

// File: rtl/bwc_pkg.sv
// Shared types for the bus wait-state control unit.
// Assumes an 8-bit control register; bit positions are set by the struct order.
package bwc_pkg;
    localparam int WAIT_W = 2;

    typedef struct packed {
        logic [WAIT_W-1:0] per_wait;    // 7:6 peripheral-area waits
        logic              vec_sel;     // 5   vector base select
        logic              irq_wen;     // 4   interrupt flag write enable
        logic              fixed_mode;  // 3   1 = fixed waits, 0 = handshake
        logic              rsvd;        // 2   always 0
        logic [WAIT_W-1:0] ext_wait;    // 1:0 external waits
    } bwc_cfg_t;

    localparam bwc_cfg_t CFG_RESET = 8'hCB;
    localparam logic [7:0] RSVD_MASK = 8'h04;

    typedef enum logic [1:0] {ST_IDLE, ST_FIXED, ST_HSHAKE} bwc_state_e;
endpackage

// File: rtl/bwc_decode.sv
// Address decoder: flags the peripheral register area and the control register.
// Assumes the peripheral area is every address at or above PERIPH_BASE.
module bwc_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = 16'hF000,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF001
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_periph,
    output logic              is_reg
);
    // Purpose: combinational area and register hit decode.
    always_comb begin
        is_periph = (addr >= PERIPH_BASE);
        is_reg    = (addr == REG_ADDR);
    end
endmodule

// File: rtl/bwc_cfg_reg.sv
// Control register: holds wait settings and interrupt steering bits.
// Assumes writes arrive as a single-clock enable at cycle completion.
module bwc_cfg_reg
    import bwc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic [7:0] wr_data,
    output bwc_cfg_t cfg
);
    // Purpose: store the register and force the reserved bit to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (wr_en) begin
            cfg <= bwc_cfg_t'(wr_data & ~RSVD_MASK);
        end
    end
endmodule

// File: rtl/bwc_cycle_fsm.sv
// Bus cycle sequencer: fixed-wait countdown or ready handshake with a watchdog.
// Assumes 'start' is only raised while idle; the wait count and mode are
// latched at acceptance, so later register changes cannot affect this cycle.
module bwc_cycle_fsm
    import bwc_pkg::*;
#(
    parameter int CW_W = bwc_pkg::WAIT_W,
    parameter int WD_LIMIT = 255
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            use_hs,
    input  logic [CW_W-1:0] wait_cnt,
    input  logic            ext_ready,
    output logic            busy,
    output logic            fin,
    output logic            done,
    output logic            abort
);
    localparam int CNT_W = CW_W + 1;
    localparam int WD_W  = $clog2(WD_LIMIT + 1);
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);

    bwc_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [WD_W-1:0]  wd;

    // Purpose: flag the edge at which the running cycle completes.
    always_comb begin
        fin = ((state == ST_FIXED) && (cnt == CNT_W'(1))) ||
              ((state == ST_HSHAKE) && (ext_ready || (wd == WD_LAST)));
        busy = (state != ST_IDLE);
    end

    // Purpose: advance the cycle state, counters and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wd    <= '0;
            done  <= 1'b0;
            abort <= 1'b0;
        end else begin
            done  <= 1'b0;
            abort <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= use_hs ? ST_HSHAKE : ST_FIXED;
                        cnt   <= {1'b0, wait_cnt} + CNT_W'(1);
                        wd    <= '0;
                    end
                end
                ST_FIXED: begin
                    if (fin) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_HSHAKE: begin
                    if (fin) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        abort <= !ext_ready;
                    end else begin
                        wd <= wd + WD_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_wait_ctrl.sv
// Top of the bus wait-state control unit: decodes each request, picks the
// wait rule, runs the cycle and commits control-register writes at completion.
// Assumes the requester holds req_valid until it sees rsp_done or drops it
// after acceptance; a request is never accepted on the clock of a done pulse.
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int VEC_W = 20,
    parameter int WD_LIMIT = 255,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = 16'hF000,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF001,
    parameter logic [VEC_W-1:0] VEC_BASE_CLR = 20'h04000,
    parameter logic [VEC_W-1:0] VEC_BASE_SET = 20'h00100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [7:0]        req_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              ext_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [7:0]        rsp_rdata,
    output logic [VEC_W-1:0]  vec_base,
    output logic              irq_flag_wr_en
);
    bwc_cfg_t          cfg_q;
    logic              dec_periph, dec_reg;
    logic              cyc_busy, cyc_fin, cyc_start;
    logic              lat_we, lat_reg;
    logic [7:0]        lat_wdata;
    logic [WAIT_W-1:0] sel_wait;
    logic              sel_hs;

    bwc_decode #(.ADDR_W(ADDR_W), .PERIPH_BASE(PERIPH_BASE), .REG_ADDR(REG_ADDR)) u_dec (
        .addr(req_addr), .is_periph(dec_periph), .is_reg(dec_reg)
    );

    // Purpose: accept a request when idle and pick its wait rule.
    always_comb begin
        cyc_start = req_valid && !cyc_busy && !rsp_done;
        sel_wait  = dec_periph ? cfg_q.per_wait : cfg_q.ext_wait;
        sel_hs    = !dec_periph && !cfg_q.fixed_mode;
    end

    // Purpose: latch the request attributes needed at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_we    <= 1'b0;
            lat_reg   <= 1'b0;
            lat_wdata <= '0;
        end else if (cyc_start) begin
            lat_we    <= req_we;
            lat_reg   <= dec_reg;
            lat_wdata <= req_wdata;
        end
    end

    bwc_cycle_fsm #(.CW_W(WAIT_W), .WD_LIMIT(WD_LIMIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(cyc_start), .use_hs(sel_hs),
        .wait_cnt(sel_wait), .ext_ready(ext_ready), .busy(cyc_busy),
        .fin(cyc_fin), .done(rsp_done), .abort(rsp_err)
    );

    bwc_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cyc_fin && lat_we && lat_reg),
        .wr_data(lat_wdata), .cfg(cfg_q)
    );

    // Purpose: steer read data and export the interrupt steering bits.
    always_comb begin
        rsp_rdata      = lat_reg ? 8'(cfg_q) : bus_rdata;
        vec_base       = cfg_q.vec_sel ? VEC_BASE_SET : VEC_BASE_CLR;
        irq_flag_wr_en = cfg_q.irq_wen;
    end
endmodule

// File: rtl/bwc_checker.sv
// Cycle-by-cycle property checker for bus_wait_ctrl, attached by bind.
// Assumes the synchronous active-low reset is asserted from time zero.
module bwc_checker #(
    parameter int VEC_W = 20,
    parameter int WD_LIMIT = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rsp_done,
    input logic             rsp_err,
    input logic [VEC_W-1:0] vec_base,
    input logic             irq_flag_wr_en,
    input logic [7:0]       cfg_bits,
    input logic             busy
);
    localparam int LEN_W = $clog2(WD_LIMIT + 2);
    logic [LEN_W-1:0] busy_len;

    // Purpose: count the clocks the current cycle has been busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + LEN_W'(1);
    end

    p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_cfg_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bits) |-> rsp_done);
    p_vec_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vec_base) |-> rsp_done);
    p_irq_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_flag_wr_en) |-> rsp_done);
    p_wd_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= LEN_W'(WD_LIMIT));
endmodule

bind bus_wait_ctrl bwc_checker #(.VEC_W(VEC_W), .WD_LIMIT(WD_LIMIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .vec_base(vec_base), .irq_flag_wr_en(irq_flag_wr_en),
    .cfg_bits(8'(cfg_q)), .busy(cyc_busy)
);

// File: tb/tb_bus_wait_ctrl.sv
`timescale 1ns/1ps
module tb_bus_wait_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  bus_rdata = '0;
    logic        ext_ready = 1'b0;
    logic        rsp_done, rsp_err, irq_flag_wr_en;
    logic [7:0]  rsp_rdata;
    logic [19:0] vec_base;

    int tests = 0;
    int fails = 0;

    localparam logic [15:0] A_EXT = 16'h1234;
    localparam logic [15:0] A_PER = 16'hF010;
    localparam logic [15:0] A_REG = 16'hF001;

    always #2.5 clk = ~clk;

    bus_wait_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
        .ext_ready(ext_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .vec_base(vec_base), .irq_flag_wr_en(irq_flag_wr_en)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [15:0] addr;
        logic [9:0]  dly;
        logic [8:0]  len;
        logic [3:0]  rq;
    } vec_t;

    // cfg layout: {per_wait[1:0], vec_sel, irq_wen, fixed_mode, rsvd, ext_wait[1:0]}
    localparam vec_t VECS [12] = '{
        '{8'h08, A_EXT, 10'd0,   9'd2, 4'd2},   // R2 ext_wait 00
        '{8'h09, A_EXT, 10'd0,   9'd3, 4'd2},   // R2 ext_wait 01
        '{8'h0A, A_EXT, 10'd0,   9'd4, 4'd2},   // R2 ext_wait 10
        '{8'h0B, A_EXT, 10'd0,   9'd5, 4'd2},   // R2 ext_wait 11
        '{8'h09, A_EXT, 10'd100, 9'd3, 4'd2},   // R2 ready ignored in fixed mode
        '{8'h08, A_PER, 10'd0,   9'd2, 4'd3},   // R3 per_wait 00
        '{8'h48, A_PER, 10'd0,   9'd3, 4'd3},   // R3 per_wait 01
        '{8'hC8, A_PER, 10'd0,   9'd5, 4'd3},   // R3 per_wait 11
        '{8'h80, A_PER, 10'd100, 9'd4, 4'd3},   // R3 handshake mode, ready ignored
        '{8'h03, A_EXT, 10'd0,   9'd2, 4'd4},   // R4 ready at once, ext_wait ignored
        '{8'h03, A_EXT, 10'd4,   9'd6, 4'd4},   // R4 four low samples
        '{8'h00, A_EXT, 10'd1,   9'd3, 4'd4}    // R4 one low sample
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Runs one bus cycle; len counts clocks from the accepting edge to done.
    task automatic run_cycle(input logic [15:0] a, input logic we, input logic [7:0] wd,
                             input int dly, output int len, output logic err,
                             output logic [7:0] rd);
        int n;
        n = 0;
        len = -1;
        err = 1'b0;
        rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        while (n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            req_valid = 1'b0;
            ext_ready = (n > dly);
            if (rsp_done) begin
                len = n; err = rsp_err; rd = rsp_rdata;
                break;
            end
        end
        ext_ready = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        int l; logic e; logic [7:0] r;
        run_cycle(A_REG, 1'b1, v, 0, l, e, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int l; logic e; logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 done", 32'(rsp_done), 32'd0);
        check("R1 err", 32'(rsp_err), 32'd0);
        check("R1 vec_base", 32'(vec_base), 32'h04000);
        check("R1 irq_wen", 32'(irq_flag_wr_en), 32'd0);
        run_cycle(A_REG, 1'b0, 8'h00, 0, l, e, r);
        check("R1 reset value", 32'(r), 32'hCB);
        check("R6 register uses per_wait 11", 32'(l), 32'd5);
        @(negedge clk);
        check("R11 done is one pulse", 32'(rsp_done), 32'd0);

        // R6 reserved bit forced to 0
        write_cfg(8'hFF);
        run_cycle(A_REG, 1'b0, 8'h00, 0, l, e, r);
        check("R6 reserved bit reads 0", 32'(r), 32'hFB);
        check("R8 vec_sel=1", 32'(vec_base), 32'h00100);
        check("R9 irq_wen=1", 32'(irq_flag_wr_en), 32'd1);

        // R7 the write cycle keeps old per_wait (3), next cycle uses new (0)
        run_cycle(A_REG, 1'b1, 8'h3B, 0, l, e, r);
        check("R7 write cycle keeps old waits", 32'(l), 32'd5);
        run_cycle(A_REG, 1'b0, 8'h00, 0, l, e, r);
        check("R7 next cycle uses new waits", 32'(l), 32'd2);
        check("R7 readback", 32'(r), 32'h3B);

        // R10 bus read data for non-register reads
        bus_rdata = 8'h5A;
        run_cycle(A_EXT, 1'b0, 8'h00, 0, l, e, r);
        check("R10 ext read data", 32'(r), 32'h5A);
        check("R2 ext_wait 11 length", 32'(l), 32'd5);
        bus_rdata = 8'hA7;
        run_cycle(A_PER, 1'b0, 8'h00, 0, l, e, r);
        check("R10 peripheral read data", 32'(r), 32'hA7);

        // R6 an external write leaves the register unchanged
        run_cycle(A_EXT, 1'b1, 8'h00, 0, l, e, r);
        run_cycle(A_REG, 1'b0, 8'h00, 0, l, e, r);
        check("R6 ext write ignored", 32'(r), 32'h3B);

        // R8 R9 clearing the steering bits
        write_cfg(8'h0B);
        check("R8 vec_sel=0", 32'(vec_base), 32'h04000);
        check("R9 irq_wen=0", 32'(irq_flag_wr_en), 32'd0);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            write_cfg(VECS[i].cfg);
            run_cycle(VECS[i].addr, 1'b0, 8'h00, int'(VECS[i].dly), l, e, r);
            check($sformatf("R%0d table %0d length", VECS[i].rq, i), 32'(l), 32'(VECS[i].len));
            check($sformatf("R11 table %0d err", i), 32'(e), 32'd0);
        end

        // R5 watchdog abort in handshake mode
        write_cfg(8'h00);
        run_cycle(A_EXT, 1'b0, 8'h00, 1000, l, e, r);
        check("R5 abort length", 32'(l), 32'd256);
        check("R5 abort err", 32'(e), 32'd1);
        run_cycle(A_EXT, 1'b0, 8'h00, 0, l, e, r);
        check("R11 err clear after abort", 32'(e), 32'd0);
        check("R4 length after abort", 32'(l), 32'd2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule